// File: doc/BRIEF.md
# Sample FIFO Status Flag Generator

This block derives three status flags for a sample FIFO: a ready flag, a watermark flag and an overrun flag. It watches the FIFO's fill count, its push and pop strobes, its full indication, its enable and its operating mode. The watermark threshold is nine bits wide and arrives in two parts. An 8-bit sample-count field supplies the low bits, and a single extension bit from a control field supplies the most significant bit.

All three flags are registered. They appear in an 8-bit status word at fixed positions, and every other bit of that word is held at zero. The FIFO storage, register access and interrupt routing sit outside the block.

The overrun flag is sticky. A push that arrives while the FIFO is full sets it, whether the FIFO overwrites its oldest data or drops the incoming sample. Any read of the FIFO clears it, and so does disabling the FIFO. If a read and a new overrun happen in the same cycle, the set wins.

Top module: `fifo_status_flags`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `status_o` reads all zeros.
- R2: The flag positions in `status_o` are fixed: ready in bit 1, watermark in bit 2, overrun in bit 3. Bits 0 and 7:4 are always 0.
- R3: The ready flag is 1 in the cycle after a clock edge that sampled `fifo_en_i`=1 and `fill_cnt_i` != 0. After any other edge it is 0.
- R4: The watermark flag is 1 in the cycle after an enabled edge at which `fill_cnt_i` >= {`thr_ext_i`, `thr_cnt_i`}. `thr_ext_i` is the threshold's bit 8, so the threshold can exceed 255.
- R5: The watermark flag returns to 0 in the cycle after an edge at which the fill count has dropped below the threshold.
- R6: A threshold of 0 keeps the watermark flag at 1 while the FIFO is enabled, even when the FIFO is empty.
- R7: In overwrite mode (`mode_i`=0), a push sampled while `full_i`=1 and enabled sets the overrun flag at the next edge.
- R8: In keep-oldest mode (`mode_i`=1), a push sampled while `full_i`=1 and enabled also sets the overrun flag.
- R9: The overrun flag stays set through cycles that have no pop and no disable. Pushes into a FIFO that is not full leave it set.
- R10: A pop sampled while enabled clears the overrun flag, unless an overrun event is sampled at the same edge. In that case the flag stays 1.
- R11: An edge that samples `fifo_en_i`=0 drives all three flags to 0, whatever the count, the threshold or any push sampled while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en_i | input | 1 | FIFO enable |
| mode_i | input | 1 | 0 = overwrite oldest, 1 = keep oldest |
| fill_cnt_i | input | CNT_W | Samples currently stored |
| push_i | input | 1 | Sample arrival strobe |
| pop_i | input | 1 | Sample read strobe |
| full_i | input | 1 | FIFO has no free entry |
| thr_cnt_i | input | THR_LO_W | Low bits of the watermark threshold |
| thr_ext_i | input | 1 | Most significant bit of the watermark threshold |
| status_o | output | STAT_W | Status word holding the three flags |

## Verification
The bench builds the block with its default parameters: a 10-bit fill count, an 8-bit low threshold field and an 8-bit status word. With these values the bench can drive counts of 256 and above, and so reach thresholds that depend on the extension bit, such as 300. It can also probe the exact equality edge at the top of the 9-bit range (511), while the zero-threshold corner stays reachable. Both FIFO modes are exercised, along with the same-cycle case where a pop and an overrun collide.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  // Positions of the flags inside the status word
  localparam int unsigned POS_READY = 1;
  localparam int unsigned POS_WMARK = 2;
  localparam int unsigned POS_OVRUN = 3;

  typedef enum logic {
    MODE_OVERWRITE = 1'b0,
    MODE_KEEP_OLD  = 1'b1
  } fifo_mode_e;

  typedef struct packed {
    logic ovrun;
    logic wmark;
    logic ready;
  } flags_t;
endpackage

// File: rtl/fsf_threshold.sv
module fsf_threshold #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned THR_LO_W = 8
) (
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [THR_LO_W-1:0] thr_lo_i,
  input  logic                thr_hi_i,
  output logic                reached_o
);
  localparam int unsigned THR_W = THR_LO_W + 1;
  localparam int unsigned CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [THR_W-1:0] thr;
  logic [CMP_W-1:0] cnt_x;
  logic [CMP_W-1:0] thr_x;

  // The extension bit is the most significant bit of the threshold
  assign thr       = {thr_hi_i, thr_lo_i};
  assign cnt_x     = CMP_W'(cnt_i);
  assign thr_x     = CMP_W'(thr);
  assign reached_o = (cnt_x >= thr_x);
endmodule

// File: rtl/fsf_level_flags.sv
module fsf_level_flags #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned THR_LO_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [THR_LO_W-1:0] thr_lo_i,
  input  logic                thr_hi_i,
  output logic                ready_o,
  output logic                wmark_o
);
  logic reached;

  fsf_threshold #(
    .CNT_W    (CNT_W),
    .THR_LO_W (THR_LO_W)
  ) u_thr (
    .cnt_i     (cnt_i),
    .thr_lo_i  (thr_lo_i),
    .thr_hi_i  (thr_hi_i),
    .reached_o (reached)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_o <= 1'b0;
      wmark_o <= 1'b0;
    end else begin
      ready_o <= en_i && (cnt_i != '0);
      wmark_o <= en_i && reached;
    end
  end
endmodule

// File: rtl/fsf_overrun.sv
module fsf_overrun
  import fsf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  fifo_mode_e mode_i,
  input  logic       push_i,
  input  logic       pop_i,
  input  logic       full_i,
  output logic       ovrun_o
);
  logic lost_sample;

  // Overwrite mode loses the oldest entry; keep-oldest mode drops the new one.
  // Either way a sample is lost and the flag is raised.
  always_comb begin
    unique case (mode_i)
      MODE_OVERWRITE: lost_sample = push_i && full_i;
      MODE_KEEP_OLD:  lost_sample = push_i && full_i;
      default:        lost_sample = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      ovrun_o <= 1'b0;
    end else if (lost_sample) begin
      ovrun_o <= 1'b1;
    end else if (pop_i) begin
      ovrun_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_status_flags.sv
module fifo_status_flags
  import fsf_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned THR_LO_W = 8,
  parameter int unsigned STAT_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fifo_en_i,
  input  logic                mode_i,
  input  logic [CNT_W-1:0]    fill_cnt_i,
  input  logic                push_i,
  input  logic                pop_i,
  input  logic                full_i,
  input  logic [THR_LO_W-1:0] thr_cnt_i,
  input  logic                thr_ext_i,
  output logic [STAT_W-1:0]   status_o
);
  flags_t flags;

  fsf_level_flags #(
    .CNT_W    (CNT_W),
    .THR_LO_W (THR_LO_W)
  ) u_level (
    .clk      (clk),
    .rst      (rst),
    .en_i     (fifo_en_i),
    .cnt_i    (fill_cnt_i),
    .thr_lo_i (thr_cnt_i),
    .thr_hi_i (thr_ext_i),
    .ready_o  (flags.ready),
    .wmark_o  (flags.wmark)
  );

  fsf_overrun u_ovr (
    .clk     (clk),
    .rst     (rst),
    .en_i    (fifo_en_i),
    .mode_i  (fifo_mode_e'(mode_i)),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .full_i  (full_i),
    .ovrun_o (flags.ovrun)
  );

  for (genvar b = 0; b < STAT_W; b++) begin : g_word
    if (b == POS_READY) begin : g_rdy
      assign status_o[b] = flags.ready;
    end else if (b == POS_WMARK) begin : g_wm
      assign status_o[b] = flags.wmark;
    end else if (b == POS_OVRUN) begin : g_ov
      assign status_o[b] = flags.ovrun;
    end else begin : g_zero
      assign status_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/fifo_status_flags_chk.sv
module fifo_status_flags_chk #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned THR_LO_W = 8,
  parameter int unsigned STAT_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                fifo_en_i,
  input logic [CNT_W-1:0]    fill_cnt_i,
  input logic                push_i,
  input logic                pop_i,
  input logic                full_i,
  input logic [THR_LO_W-1:0] thr_cnt_i,
  input logic                thr_ext_i,
  input logic [STAT_W-1:0]   status_o
);
  // R2
  unused_bits_chk: assert property (@(posedge clk) disable iff (rst)
    status_o[0] == 1'b0 && (status_o >> 4) == '0);

  // R3
  ready_set_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en_i && fill_cnt_i != '0) |=> status_o[1]);

  // R6
  zero_thr_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en_i && thr_cnt_i == '0 && !thr_ext_i) |=> status_o[2]);

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en_i && push_i && full_i) |=> status_o[3]);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en_i && status_o[3] && !pop_i) |=> status_o[3]);

  // R10
  ovr_pop_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en_i && pop_i && !(push_i && full_i)) |=> !status_o[3]);

  // R11
  disable_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !fifo_en_i |=> (status_o[3:1] == 3'b000));
endmodule

bind fifo_status_flags fifo_status_flags_chk #(
  .CNT_W    (CNT_W),
  .THR_LO_W (THR_LO_W),
  .STAT_W   (STAT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_en_i  (fifo_en_i),
  .fill_cnt_i (fill_cnt_i),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .full_i     (full_i),
  .thr_cnt_i  (thr_cnt_i),
  .thr_ext_i  (thr_ext_i),
  .status_o   (status_o)
);

// File: tb/fifo_status_flags_tb.sv
module fifo_status_flags_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       fifo_en;
  logic       mode;
  logic [9:0] fill_cnt;
  logic       push;
  logic       pop;
  logic       full;
  logic [7:0] thr_cnt;
  logic       thr_ext;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_status_flags u_dut (
    .clk        (clk),
    .rst        (rst),
    .fifo_en_i  (fifo_en),
    .mode_i     (mode),
    .fill_cnt_i (fill_cnt),
    .push_i     (push),
    .pop_i      (pop),
    .full_i     (full),
    .thr_cnt_i  (thr_cnt),
    .thr_ext_i  (thr_ext),
    .status_o   (status)
  );

  function automatic logic [7:0] word(input logic r, input logic w, input logic o);
    return {4'b0000, o, w, r, 1'b0};
  endfunction

  // Sample one time unit after the edge, away from it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s: status actual %b expected %b", req, status, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; fifo_en = 1'b1; mode = 1'b0; fill_cnt = 10'd5;
    push = 1'b1; pop = 1'b0; full = 1'b1; thr_cnt = 8'd0; thr_ext = 1'b0;
    step();
    check("R1 during reset", 8'h00);
    step();
    check("R1 held reset", 8'h00);
    rst = 1'b0; push = 1'b0; full = 1'b0; fill_cnt = 10'd0; thr_cnt = 8'h80;
    step();
    check("R1 first cycle after reset", 8'h00);
  endtask

  task automatic t_ready();
    fill_cnt = 10'd1;
    step();
    check("R3 ready with one sample, R2 position", word(1, 0, 0));
    fill_cnt = 10'd0;
    step();
    check("R3 ready low when empty", word(0, 0, 0));
  endtask

  task automatic t_watermark();
    thr_ext = 1'b1; thr_cnt = 8'd44; // threshold 300
    fill_cnt = 10'd299;
    step();
    check("R4 count just below 300", word(1, 0, 0));
    fill_cnt = 10'd300;
    step();
    check("R4 count equal 300 with extension bit", word(1, 1, 0));
    fill_cnt = 10'd44;
    step();
    check("R4 low byte alone not enough", word(1, 0, 0));
    thr_cnt = 8'd255; fill_cnt = 10'd511;
    step();
    check("R4 threshold 511 reached", word(1, 1, 0));
    fill_cnt = 10'd510;
    step();
    check("R5 cleared below threshold", word(1, 0, 0));
    thr_ext = 1'b0; thr_cnt = 8'h80;
    fill_cnt = 10'd0;
    step();
  endtask

  task automatic t_zero_thr();
    thr_cnt = 8'd0; thr_ext = 1'b0; fill_cnt = 10'd0;
    step();
    check("R6 zero threshold on empty FIFO", word(0, 1, 0));
    thr_cnt = 8'h80;
    step();
    check("R6 nonzero threshold releases flag", word(0, 0, 0));
  endtask

  task automatic t_overrun(input logic m, input string req);
    mode = m; fill_cnt = 10'd512; full = 1'b1;
    push = 1'b1;
    step();
    check(req, word(1, 1, 1));
    push = 1'b0; full = 1'b0; fill_cnt = 10'd511;
    step();
    check("R9 sticky without pop", word(1, 1, 1));
    push = 1'b1;
    step();
    check("R9 push into non-full keeps flag", word(1, 1, 1));
    push = 1'b0; pop = 1'b1; fill_cnt = 10'd510;
    step();
    check("R10 pop clears overrun", word(1, 1, 0));
    pop = 1'b0;
    step();
  endtask

  task automatic t_collision();
    mode = 1'b1; fill_cnt = 10'd512; full = 1'b1; push = 1'b1; pop = 1'b1;
    step();
    check("R10 set wins over same-cycle pop", word(1, 1, 1));
    push = 1'b0; full = 1'b0; fill_cnt = 10'd511;
    step();
    check("R10 pop alone then clears", word(1, 1, 0));
    pop = 1'b0;
  endtask

  task automatic t_disable();
    fill_cnt = 10'd512; full = 1'b1; push = 1'b1;
    step();
    check("R11 setup overrun", word(1, 1, 1));
    fifo_en = 1'b0; thr_cnt = 8'd0;
    step();
    check("R11 disable forces all flags low", word(0, 0, 0));
    step();
    check("R11 push while full ignored when disabled", word(0, 0, 0));
    push = 1'b0; full = 1'b0; fifo_en = 1'b1; thr_cnt = 8'h80; fill_cnt = 10'd3;
    step();
    check("R11 overrun stays cleared after re-enable", word(1, 0, 0));
  endtask

  initial begin
    t_reset();
    t_ready();
    t_watermark();
    t_zero_thr();
    t_overrun(1'b0, "R7 overwrite mode overrun");
    t_overrun(1'b1, "R8 keep-oldest mode overrun");
    t_collision();
    t_disable();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule